// File: doc/BRIEF.md
# Display Controller Register Bank

This block is the software-visible register file of a display controller. It holds the global control and configuration words, the panel and digital-output sizes, the timing words, the background and colour-key values and the graphics-layer setup. It turns them into the few live signals the display pipeline needs: the two output enables, the layer enable and its pixel format, a level interrupt, and a one-cycle pulse that tells the pipeline to redraw when a register affecting the picture has been rewritten.

Software reaches the block through a simple word-addressed port with separate write and read strobes. Read data is registered and appears in the cycle after the read strobe. The display pipeline reports events, with frame done on bit 0, as single-cycle pulses on the event input. Each event sets its own status bit. The interrupt line is high while any status bit is also enabled. Status bits are cleared by writing one to them.

Top module: `disp_regbank`

## Requirements
- R1: After reset every register reads zero, with these exceptions: the capability word reads 0x161, the row-increment and pixel-increment words read 1, and the system status word reads 1.
- R2: `irq` is high exactly when some bit is set in both the status word and the enable word. It follows any change of either word in the cycle after the clock edge that makes the change.
- R3: A write to the status word clears each status bit written as one and leaves bits written as zero unchanged.
- R4: An event pulse on bit n of `evt` sets status bit n at the next clock edge. When software clears the same bit in the same cycle, the bit ends up set.
- R5: The enable word keeps only bits 15:0 of a write.
- R6: The control word stores a write under mask 0x07FF9FFF. `lcd_en` follows control bit 0 and `dig_en` follows control bit 1.
- R7: The two output-size words and the layer-size word keep an 11-bit width minus one in bits 10:0 and an 11-bit height minus one in bits 26:16, and read back in that same encoding. The layer-position word keeps X in bits 10:0 and Y in bits 26:16 with no offset.
- R8: The layer-attribute word keeps bits 10:0. `gfx_en` follows bit 0 and `gfx_fmt` follows bits 4:1.
- R9: Other stored masks: configuration 0x3FFF, capability 0x3FF, background and colour-key words 0xFFFFFF, line number 0x7FF, both timing words 0x0FF0FF3F, polarity/frequency 0x0003FFFF, divisor 0x00FF00FF, layer FIFO thresholds 0x01FF01FF. Both layer base addresses, the table address, both increments and the window skip keep all 32 bits.
- R10: The system-config word keeps mask 0x301B. A write with bit 1 set returns every other register to its reset value at that edge, and the system-config word then holds the masked written value. The system status word always reads 1 and ignores writes.
- R11: `invalidate` pulses for one cycle, in the cycle after the edge that accepts a write to the control, configuration, background, colour-key, size, layer base, position, layer size, attribute, increment or table-address words. Writes to any other word leave it low.
- R12: Word offsets 0x70 and above read as zero, and writes to them change no register.
- R13: `rdata` shows the addressed word, as it was before any write in the same cycle, in the cycle after `rd_en`. It is zero in every cycle that follows a cycle without `rd_en`.
- R14: Byte offsets, with `addr[1:0]` ignored: 0x00 system config, 0x04 system status, 0x08 status, 0x0C enable, 0x10 control, 0x14 configuration, 0x18 capability, 0x1C/0x20 backgrounds, 0x24/0x28 colour keys, 0x2C line number, 0x30/0x34 horizontal/vertical timing, 0x38 polarity/frequency, 0x3C divisor, 0x40 panel size, 0x44 digital size, 0x48/0x4C layer bases, 0x50 layer position, 0x54 layer size, 0x58 attribute, 0x5C FIFO thresholds, 0x60 row increment, 0x64 pixel increment, 0x68 window skip, 0x6C table address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| evt | input | EVT_W | Pipeline event pulses, bit 0 is frame done |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |
| lcd_en | output | 1 | Panel output enable |
| dig_en | output | 1 | Digital output enable |
| gfx_en | output | 1 | Graphics layer enable |
| gfx_fmt | output | 4 | Graphics layer pixel format code |
| invalidate | output | 1 | One-cycle redraw request |

## Verification
On every cycle the assertions check the write-one-to-clear arithmetic, that an event always lands in the status word, that a redraw pulse and a rising panel enable are always preceded by a matching write, that a soft reset restores the capability and increment defaults, and that idle or unmapped reads return zero. The store masks, the exact set of words that request a redraw, the set-beats-clear collision, the order of a read against a same-cycle write, and the whole address map can only be shown by the scenarios. In those scenarios a behavioural model of the register file is compared with every output on every clock.

// File: rtl/disp_regbank.sv
module disp_regbank #(
  parameter int ADDR_W = 8,
  parameter int EVT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [EVT_W-1:0]  evt,
  output logic [31:0]       rdata,
  output logic              irq,
  output logic              lcd_en,
  output logic              dig_en,
  output logic              gfx_en,
  output logic [3:0]        gfx_fmt,
  output logic              invalidate
);

  localparam int IDX_W = ADDR_W - 2;
  localparam int NREG  = 28;

  localparam int W_SYSCFG = 0;
  localparam int W_SYSST  = 1;
  localparam int W_STAT   = 2;
  localparam int W_IEN    = 3;
  localparam int W_CTRL   = 4;
  localparam int W_CFG    = 5;
  localparam int W_CAPS   = 6;
  localparam int W_BG0    = 7;
  localparam int W_BG1    = 8;
  localparam int W_KEY0   = 9;
  localparam int W_KEY1   = 10;
  localparam int W_LINE   = 11;
  localparam int W_HTIM   = 12;
  localparam int W_VTIM   = 13;
  localparam int W_POL    = 14;
  localparam int W_DIV    = 15;
  localparam int W_SZLCD  = 16;
  localparam int W_SZDIG  = 17;
  localparam int W_BASE0  = 18;
  localparam int W_BASE1  = 19;
  localparam int W_POS    = 20;
  localparam int W_GSIZE  = 21;
  localparam int W_ATTR   = 22;
  localparam int W_FIFO   = 23;
  localparam int W_ROWINC = 24;
  localparam int W_PIXINC = 25;
  localparam int W_SKIP   = 26;
  localparam int W_TABLE  = 27;

  function automatic logic [31:0] keep_mask(input int i);
    case (i)
      W_SYSCFG:                    keep_mask = 32'h0000_301B;
      W_SYSST:                     keep_mask = 32'h0000_0000;
      W_STAT, W_IEN:               keep_mask = 32'h0000_FFFF;
      W_CTRL:                      keep_mask = 32'h07FF_9FFF;
      W_CFG:                       keep_mask = 32'h0000_3FFF;
      W_CAPS:                      keep_mask = 32'h0000_03FF;
      W_BG0, W_BG1, W_KEY0, W_KEY1: keep_mask = 32'h00FF_FFFF;
      W_LINE:                      keep_mask = 32'h0000_07FF;
      W_HTIM, W_VTIM:              keep_mask = 32'h0FF0_FF3F;
      W_POL:                       keep_mask = 32'h0003_FFFF;
      W_DIV:                       keep_mask = 32'h00FF_00FF;
      W_SZLCD, W_SZDIG, W_POS, W_GSIZE: keep_mask = 32'h07FF_07FF;
      W_ATTR:                      keep_mask = 32'h0000_07FF;
      W_FIFO:                      keep_mask = 32'h01FF_01FF;
      default:                     keep_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] init_val(input int i);
    case (i)
      W_CAPS:           init_val = 32'h0000_0161;
      W_ROWINC, W_PIXINC: init_val = 32'h0000_0001;
      default:          init_val = 32'h0;
    endcase
  endfunction

  function automatic logic redraws(input int i);
    case (i)
      W_CTRL, W_CFG, W_BG0, W_BG1, W_KEY0, W_KEY1, W_SZLCD, W_SZDIG,
      W_BASE0, W_BASE1, W_POS, W_GSIZE, W_ATTR, W_ROWINC, W_PIXINC,
      W_TABLE: redraws = 1'b1;
      default: redraws = 1'b0;
    endcase
  endfunction

  logic [31:0]      regs [NREG];
  logic [IDX_W-1:0] widx;
  logic             hit;
  logic             soft_rst;
  logic [31:0]      evt_w;
  logic [31:0]      st_clr;
  logic [31:0]      rd_mux;

  assign widx     = addr[ADDR_W-1:2];
  assign hit      = widx < IDX_W'(NREG);
  assign soft_rst = wr_en && (widx == IDX_W'(W_SYSCFG)) && wdata[1];
  assign evt_w    = 32'(evt);
  assign st_clr   = (wr_en && widx == IDX_W'(W_STAT)) ? wdata : 32'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= init_val(i);
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (i == W_STAT)
          regs[i] <= ((soft_rst ? 32'h0 : (regs[i] & ~st_clr)) | evt_w) & keep_mask(i);
        else if (wr_en && widx == IDX_W'(i) && i != W_SYSST)
          regs[i] <= wdata & keep_mask(i);
        else if (soft_rst)
          regs[i] <= init_val(i);
      end
    end
  end

  always_comb begin
    rd_mux = 32'h0;
    for (int i = 0; i < NREG; i++)
      if (widx == IDX_W'(i)) rd_mux = regs[i];
    if (widx == IDX_W'(W_SYSST)) rd_mux = 32'h1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata      <= 32'h0;
      invalidate <= 1'b0;
    end else begin
      rdata      <= rd_en ? rd_mux : 32'h0;
      invalidate <= wr_en && hit && redraws(int'(widx));
    end
  end

  assign irq     = |(regs[W_STAT][15:0] & regs[W_IEN][15:0]);
  assign lcd_en  = regs[W_CTRL][0];
  assign dig_en  = regs[W_CTRL][1];
  assign gfx_en  = regs[W_ATTR][0];
  assign gfx_fmt = regs[W_ATTR][4:1];

  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == IDX_W'(W_STAT) && evt == '0)
      |=> regs[W_STAT][15:0] == ($past(regs[W_STAT][15:0]) & ~$past(wdata[15:0])));

  p_evt_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt[0] |=> regs[W_STAT][0]);

  p_inval_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    invalidate |-> $past(wr_en));

  p_lcd_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_en) |-> $past(wr_en && widx == IDX_W'(W_CTRL)));

  p_soft_defaults_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (regs[W_CAPS] == 32'h161 && regs[W_ROWINC] == 32'h1 && regs[W_PIXINC] == 32'h1));

  p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit) |=> rdata == 32'h0);

  p_idle_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rdata == 32'h0);

endmodule

// File: tb/disp_regbank_tb.sv
module disp_regbank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] evt = '0;
  logic [31:0] rdata;
  logic        irq, lcd_en, dig_en, gfx_en, invalidate;
  logic [3:0]  gfx_fmt;

  always #5 clk = ~clk;

  disp_regbank #(.ADDR_W(8), .EVT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .evt(evt), .rdata(rdata), .irq(irq), .lcd_en(lcd_en),
    .dig_en(dig_en), .gfx_en(gfx_en), .gfx_fmt(gfx_fmt), .invalidate(invalidate)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    cmp_on = 0;
  bit    done = 0;
  string phase = "R1";

  logic [31:0] m [28];
  logic [31:0] m_rd = '0;
  logic        m_inv = 1'b0;

  function automatic logic [31:0] msk(input int i);
    case (i)
      0: return 32'h301B;   1: return 32'h0;
      2, 3: return 32'hFFFF; 4: return 32'h07FF9FFF;
      5: return 32'h3FFF;   6: return 32'h3FF;
      7, 8, 9, 10: return 32'hFFFFFF;
      11: return 32'h7FF;   12, 13: return 32'h0FF0FF3F;
      14: return 32'h3FFFF; 15: return 32'h00FF00FF;
      16, 17, 20, 21: return 32'h07FF07FF;
      22: return 32'h7FF;   23: return 32'h01FF01FF;
      default: return 32'hFFFFFFFF;
    endcase
  endfunction

  function automatic logic [31:0] dflt(input int i);
    if (i == 6) return 32'h161;
    if (i == 24 || i == 25) return 32'h1;
    return 32'h0;
  endfunction

  function automatic bit redraw(input int i);
    return (i == 4 || i == 5 || (i >= 7 && i <= 10) || i == 16 || i == 17 ||
            (i >= 18 && i <= 22) || i == 24 || i == 25 || i == 27);
  endfunction

  function automatic string tag_of(input int i);
    if (i == 3) return "R5";
    if (i == 4) return "R6";
    if (i == 16 || i == 17 || i == 20 || i == 21) return "R7";
    if (i == 22) return "R8";
    return "R9";
  endfunction

  always @(posedge clk) begin : model
    int wi;
    wi = int'(addr[7:2]);
    if (!rst_n) begin
      for (int k = 0; k < 28; k++) m[k] = dflt(k);
      m_rd = '0;
      m_inv = 1'b0;
    end else begin
      m_rd = '0;
      if (rd_en) begin
        if (wi == 1) m_rd = 32'h1;
        else if (wi < 28) m_rd = m[wi];
      end
      m_inv = wr_en && wi < 28 && redraw(wi);
      if (wr_en && wi < 28) begin
        if (wi == 2) m[2] = m[2] & ~wdata;
        else if (wi == 0) begin
          if (wdata[1]) for (int k = 0; k < 28; k++) m[k] = dflt(k);
          m[0] = wdata & msk(0);
        end else if (wi != 1) m[wi] = wdata & msk(wi);
      end
      m[2] = (m[2] | {16'h0, evt}) & 32'hFFFF;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h phase=%s t=%0t", tag, what, act, exp, phase, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(phase, "rdata", rdata, m_rd);
      chk("R2", "irq", 32'(irq), 32'(|(m[2][15:0] & m[3][15:0])));
      chk("R11", "invalidate", 32'(invalidate), 32'(m_inv));
      chk("R6", "lcd_en", 32'(lcd_en), 32'(m[4][0]));
      chk("R6", "dig_en", 32'(dig_en), 32'(m[4][1]));
      chk("R8", "gfx_en", 32'(gfx_en), 32'(m[22][0]));
      chk("R8", "gfx_fmt", 32'(gfx_fmt), 32'(m[22][4:1]));
    end
  end

  task automatic cyc(input logic w, input logic r, input logic [7:0] a,
                     input logic [31:0] d, input logic [15:0] e);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d; evt = e;
  endtask

  task automatic idle();
    cyc(0, 0, 8'h0, 32'h0, 16'h0);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    cyc(1, 0, 8'(a), d, 16'h0);
  endtask

  task automatic rd(input int a);
    cyc(0, 1, 8'(a), 32'h0, 16'h0);
  endtask

  task automatic read_all();
    for (int i = 0; i < 28; i++) rd(i * 4);
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired phase=%s", phase);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp_on = 1;
    rst_n = 1'b1;

    phase = "R1";
    read_all();

    for (int i = 3; i < 28; i++) begin
      phase = tag_of(i);
      wr(i * 4, 32'hFFFF_FFFF);
      rd(i * 4);
      wr(i * 4, 32'h5A5A_A5A5);
      rd(i * 4);
    end
    idle();
    phase = "R14";
    read_all();

    phase = "R11";
    wr(11 * 4, 32'h123);
    wr(12 * 4, 32'h1);
    wr(7 * 4, 32'hABCDEF);
    idle();
    wr(26 * 4, 32'h7);
    wr(27 * 4, 32'h7);
    idle();

    phase = "R3";
    wr(3 * 4, 32'h0000_0005);
    cyc(0, 0, 8'h0, 32'h0, 16'h0003);
    idle();
    rd(2 * 4);
    wr(2 * 4, 32'h0000_0001);
    rd(2 * 4);
    wr(2 * 4, 32'hFFFF_0000);
    rd(2 * 4);
    phase = "R2";
    cyc(0, 0, 8'h0, 32'h0, 16'h8000);
    wr(3 * 4, 32'h0000_8000);
    wr(3 * 4, 32'h0000_0000);
    wr(2 * 4, 32'hFFFF_FFFF);
    idle();

    phase = "R4";
    cyc(0, 0, 8'h0, 32'h0, 16'h0001);
    wr(3 * 4, 32'h1);
    cyc(1, 0, 8'h08, 32'h0000_0001, 16'h0001);
    rd(2 * 4);
    cyc(1, 0, 8'h08, 32'h0000_0003, 16'h0002);
    rd(2 * 4);
    idle();

    phase = "R6";
    wr(4 * 4, 32'h1);
    wr(4 * 4, 32'h2);
    wr(4 * 4, 32'h3);
    wr(4 * 4, 32'h0);
    idle();

    phase = "R8";
    wr(22 * 4, 32'h0000_001F);
    wr(22 * 4, 32'h0000_0014);
    idle();

    phase = "R12";
    for (int a = 8'h70; a <= 8'hFC; a += 16) begin
      wr(a, 32'hFFFF_FFFF);
      rd(a);
    end
    rd(8'hFF);
    idle();
    read_all();

    phase = "R13";
    cyc(1, 1, 8'h1C, 32'h0011_2233, 16'h0);
    rd(8'h1C);
    idle();
    idle();

    phase = "R10";
    wr(4 * 4, 32'h3);
    wr(6 * 4, 32'h3FF);
    wr(24 * 4, 32'h44);
    wr(1 * 4, 32'hFFFF_FFFF);
    cyc(1, 0, 8'h00, 32'hFFFF_FFFF, 16'h0002);
    idle();
    read_all();
    wr(0, 32'h0000_0011);
    rd(0);
    rd(4);
    idle();

    phase = "R1";
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    read_all();

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule